// File: doc/BRIEF.md
# Compare Match Interval Timer

This block is a single interval timer channel. A free-running divider derived from the system clock emits a one-cycle count pulse every 8, 32, 128 or 512 cycles. On each pulse, while counting is enabled, a 16-bit up-counter advances by one. When a pulse finds the counter equal to a programmable constant, the counter returns to zero and a sticky match flag sets. The flag, gated by an enable bit, drives a level interrupt request. A programmed constant C therefore gives a match every (C+1) count pulses.

Software reaches the channel through a plain register port with a write strobe, a read strobe, a 2-bit address and 16-bit data. Read data is combinational from the address. The read strobe matters only for the flag-clear handshake. There is no data stream at the edge, so no valid/ready pairing applies. A standby clear input returns the counter and the divider phase to zero.

Register map (address: contents):
- 0, control: bit 0 is the run bit, bit 1 is the interrupt enable, bits 3:2 are the divisor select.
- 1, status: bit 0 is the match flag.
- 2: the counter.
- 3: the compare constant.

Top module: `cmp_interval_timer`

## Requirements
- R1: After reset, the control register reads 0x0000, status reads 0x0000, the counter reads 0x0000, the constant reads 0xFFFF, and irq is low.
- R2: The divisor select (control bits 3:2) chooses a count pulse every 8, 32, 128 or 512 system clocks, for codes 00, 01, 10 and 11. A change of select takes effect at the next pulse.
- R3: The counter (address 2) is 16 bits wide. A value written to it reads back unchanged.
- R4: The counter changes only on a count pulse while the run bit (control bit 0) is 1. With the run bit at 0 it holds its value.
- R5: A count pulse that finds the counter equal to the constant clears the counter to 0x0000 and sets the match flag. Successive matches are therefore (C+1)·D system clocks apart, where C is the constant and D is the divisor.
- R6: The match flag (status bit 0) is sticky. It clears only when a write of 0 to bit 0 of status follows a read of status that returned the flag as 1. A write of 0 without that read leaves the flag set.
- R7: If a match occurs in the same cycle as a valid flag clear, the flag stays set.
- R8: irq is a level signal and is high exactly when the match flag and the interrupt enable (control bit 1) are both 1.
- R9: A software write to the counter in the cycle of a count pulse loads the written value, and the increment is lost.
- R10: While standby_clr is high at a clock edge, the counter and the divider phase go to zero. After release, the first divide-by-8 pulse lands on the eighth edge.
- R11: The constant register (address 3) is read/write. With the constant at 0xFFFF, the counter reaches 0xFFFF and clears to 0x0000 on the next pulse with the flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| standby_clr | input | 1 | Synchronous clear of counter and divider phase |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (arms the flag clear) |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 16 | Register write data |
| bus_rdata | output | 16 | Register read data, combinational from bus_addr |
| irq | output | 1 | Compare-match interrupt request, level |

## Verification
The bench sweeps all four divisors against constants 0, 1 and 3 and measures the spacing of interrupt edges. An off-by-one compare, such as matching on the value after the increment, would give a spacing of C·D instead of (C+1)·D. The bench aligns a counter write and a flag clear to the exact cycle of a count pulse. A design with the wrong priority would show the incremented value, or would lose a match that arrived during the clear. It also clears without a prior read, where a flag missing its read-arm step would drop. Finally, it releases standby and times the first pulse, which catches a divider phase that survives the clear.

// File: rtl/cmt_pkg.sv
package cmt_pkg;
  typedef enum logic [1:0] {
    REG_CTRL  = 2'd0,
    REG_STAT  = 2'd1,
    REG_COUNT = 2'd2,
    REG_CONST = 2'd3
  } reg_addr_e;

  localparam int CTRL_RUN_BIT = 0;
  localparam int CTRL_IE_BIT  = 1;
  localparam int CTRL_SEL_LO  = 2;
  localparam int STAT_FLAG_BIT = 0;
endpackage

// File: rtl/cmt_prescaler.sv
module cmt_prescaler #(
  parameter int BASE_LOG2 = 3,
  parameter int STEP_LOG2 = 2,
  parameter int SEL_W     = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sync_clr,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  localparam int N_SEL = 1 << SEL_W;
  localparam int PRE_W = BASE_LOG2 + STEP_LOG2 * (N_SEL - 1);

  logic [PRE_W-1:0] phase;
  logic [N_SEL-1:0] taps;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        phase <= '0;
    else if (sync_clr) phase <= '0;
    else               phase <= phase + 1'b1;
  end

  generate
    for (genvar g = 0; g < N_SEL; g++) begin : g_tap
      localparam int SH = BASE_LOG2 + STEP_LOG2 * g;
      assign taps[g] = &phase[SH-1:0];
    end
  endgenerate

  assign tick = taps[sel];

  a_r2_no_back_to_back: assert property (@(posedge clk) disable iff (!rst_n || sync_clr)
    tick |=> !tick);

  a_r10_phase_restart: assert property (@(posedge clk) disable iff (!rst_n)
    sync_clr |=> !tick);
endmodule

// File: rtl/cmt_counter.sv
module cmt_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sync_clr,
  input  logic             tick,
  input  logic             run,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic [CNT_W-1:0] limit,
  output logic [CNT_W-1:0] count,
  output logic             match
);
  logic step;

  assign step  = tick && run;
  assign match = step && !sync_clr && !load && (count == limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        count <= '0;
    else if (sync_clr) count <= '0;
    else if (load)     count <= load_val;
    else if (step)     count <= (count == limit) ? '0 : count + 1'b1;
  end

  a_r4_hold_when_stopped: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !load && !sync_clr) |=> $stable(count));

  a_r5_clear_on_match: assert property (@(posedge clk) disable iff (!rst_n)
    match |=> (count == '0));

  a_r9_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !sync_clr) |=> (count == $past(load_val)));

  a_r10_standby_zero: assert property (@(posedge clk) disable iff (!rst_n)
    sync_clr |=> (count == '0));
endmodule

// File: rtl/cmt_flag.sv
module cmt_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic match,
  input  logic stat_rd,
  input  logic stat_wr,
  input  logic stat_wbit,
  output logic flag
);
  logic armed;
  logic clr_req;

  assign clr_req = stat_wr && armed && !stat_wbit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag  <= 1'b0;
      armed <= 1'b0;
    end else begin
      if (match)        flag <= 1'b1;
      else if (clr_req) flag <= 1'b0;
      if (stat_wr)                armed <= 1'b0;
      else if (stat_rd && flag)   armed <= 1'b1;
    end
  end

  a_r7_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    match |=> flag);

  a_r6_clear_needs_read: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !armed) |=> flag);
endmodule

// File: rtl/cmp_interval_timer.sv
module cmp_interval_timer
  import cmt_pkg::*;
#(
  parameter int CNT_W     = 16,
  parameter int SEL_W     = 2,
  parameter int BASE_LOG2 = 3,
  parameter int STEP_LOG2 = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             standby_clr,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [1:0]       bus_addr,
  input  logic [CNT_W-1:0] bus_wdata,
  output logic [CNT_W-1:0] bus_rdata,
  output logic             irq
);
  localparam int SEL_HI = CTRL_SEL_LO + SEL_W - 1;

  reg_addr_e        addr;
  logic             run_q;
  logic             ie_q;
  logic [SEL_W-1:0] sel_q;
  logic [CNT_W-1:0] limit_q;
  logic             tick;
  logic [CNT_W-1:0] count;
  logic             match;
  logic             flag;
  logic             wr_ctrl, wr_stat, wr_count, wr_const, rd_stat;

  assign addr     = reg_addr_e'(bus_addr);
  assign wr_ctrl  = bus_wr && (addr == REG_CTRL);
  assign wr_stat  = bus_wr && (addr == REG_STAT);
  assign wr_count = bus_wr && (addr == REG_COUNT);
  assign wr_const = bus_wr && (addr == REG_CONST);
  assign rd_stat  = bus_rd && (addr == REG_STAT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q   <= 1'b0;
      ie_q    <= 1'b0;
      sel_q   <= '0;
      limit_q <= '1;
    end else begin
      if (wr_ctrl) begin
        run_q <= bus_wdata[CTRL_RUN_BIT];
        ie_q  <= bus_wdata[CTRL_IE_BIT];
        sel_q <= bus_wdata[SEL_HI:CTRL_SEL_LO];
      end
      if (wr_const) limit_q <= bus_wdata;
    end
  end

  cmt_prescaler #(
    .BASE_LOG2(BASE_LOG2),
    .STEP_LOG2(STEP_LOG2),
    .SEL_W    (SEL_W)
  ) u_pre (
    .clk     (clk),
    .rst_n   (rst_n),
    .sync_clr(standby_clr),
    .sel     (sel_q),
    .tick    (tick)
  );

  cmt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .sync_clr(standby_clr),
    .tick    (tick),
    .run     (run_q),
    .load    (wr_count),
    .load_val(bus_wdata),
    .limit   (limit_q),
    .count   (count),
    .match   (match)
  );

  cmt_flag u_flag (
    .clk      (clk),
    .rst_n    (rst_n),
    .match    (match),
    .stat_rd  (rd_stat),
    .stat_wr  (wr_stat),
    .stat_wbit(bus_wdata[STAT_FLAG_BIT]),
    .flag     (flag)
  );

  assign irq = flag && ie_q;

  always_comb begin
    bus_rdata = '0;
    case (addr)
      REG_CTRL: begin
        bus_rdata[CTRL_RUN_BIT]         = run_q;
        bus_rdata[CTRL_IE_BIT]          = ie_q;
        bus_rdata[SEL_HI:CTRL_SEL_LO]   = sel_q;
      end
      REG_STAT:  bus_rdata[STAT_FLAG_BIT] = flag;
      REG_COUNT: bus_rdata = count;
      REG_CONST: bus_rdata = limit_q;
      default:   bus_rdata = '0;
    endcase
  end

  a_r8_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && !bus_wdata[CTRL_IE_BIT]) |=> !irq);
endmodule

// File: tb/cmp_interval_timer_test.sv
module cmp_interval_timer_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        standby_clr = 1'b0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [1:0]  bus_addr = 2'd0;
  logic [15:0] bus_wdata = 16'd0;
  logic [15:0] bus_rdata;
  logic        irq;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  cmp_interval_timer uut (
    .clk(clk), .rst_n(rst_n), .standby_clr(standby_clr),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic peek(input logic [1:0] a, output logic [15:0] v);
    bus_addr = a;
    #1 v = bus_rdata;
  endtask

  task automatic clear_flag();
    rd(2'd1);
    wr(2'd1, 16'h0000);
  endtask

  task automatic wait_irq();
    while (!irq) @(negedge clk);
  endtask

  task automatic wait_count_change();
    logic [15:0] a0, a1;
    peek(2'd2, a0);
    a1 = a0;
    while (a1 == a0) begin
      @(negedge clk);
      peek(2'd2, a1);
    end
  endtask

  initial begin
    #2_000_000;
    fails++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [15:0] v;
    int t1, t2;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    peek(2'd0, v); check("R1 ctrl", v, 16'h0000);
    peek(2'd1, v); check("R1 stat", v, 16'h0000);
    peek(2'd2, v); check("R1 count", v, 16'h0000);
    peek(2'd3, v); check("R1 const", v, 16'hFFFF);
    check("R1 irq", irq, 0);

    // R4 stopped counter holds
    repeat (100) @(negedge clk);
    peek(2'd2, v); check("R4 hold while stopped", v, 0);

    // R3 readback
    wr(2'd2, 16'h1234);
    peek(2'd2, v); check("R3 count readback", v, 16'h1234);
    repeat (40) @(negedge clk);
    peek(2'd2, v); check("R4 hold after write", v, 16'h1234);

    // R2/R5 period sweep
    for (int s = 0; s < 4; s++) begin
      for (int ci = 0; ci < 3; ci++) begin
        int c;
        int d;
        c = (ci == 0) ? 0 : (ci == 1) ? 1 : 3;
        d = 8 << (2 * s);
        wr(2'd0, 16'h0000);
        wr(2'd2, 16'h0000);
        wr(2'd3, 16'(c));
        clear_flag();
        wr(2'd0, 16'((s << 2) | 3));
        wait_irq();
        t1 = cyc;
        peek(2'd2, v); check("R5 count zero at match", v, 0);
        clear_flag();
        check("R6 flag cleared", irq, 0);
        wait_irq();
        t2 = cyc;
        check("R2 R5 match spacing", t2 - t1, (c + 1) * d);
      end
    end

    // R9 write beats increment
    wr(2'd0, 16'h0000);
    wr(2'd3, 16'hFFFF);
    wr(2'd2, 16'h0010);
    wr(2'd0, 16'h0001);
    wait_count_change();
    repeat (7) @(negedge clk);
    wr(2'd2, 16'h0100);
    peek(2'd2, v); check("R9 load on pulse", v, 16'h0100);
    repeat (7) @(negedge clk);
    peek(2'd2, v); check("R2 no pulse before 8", v, 16'h0100);
    @(negedge clk);
    peek(2'd2, v); check("R2 pulse at 8", v, 16'h0101);

    // R7 set wins over clear
    wr(2'd0, 16'h0000);
    wr(2'd3, 16'h0000);
    wr(2'd2, 16'h0000);
    clear_flag();
    wr(2'd0, 16'h0003);
    wait_irq();
    rd(2'd1);
    repeat (6) @(negedge clk);
    wr(2'd1, 16'h0000);
    peek(2'd1, v); check("R7 set wins", v, 1);

    // R6 clear without read is ignored
    wr(2'd0, 16'h0002);
    wr(2'd1, 16'h0000);
    peek(2'd1, v); check("R6 no clear without read", v, 1);
    check("R6 irq still high", irq, 1);
    clear_flag();
    peek(2'd1, v); check("R6 clear after read", v, 0);

    // R8 irq gating
    wr(2'd2, 16'h0000);
    wr(2'd0, 16'h0001);
    v = 0;
    while (v == 0) begin
      @(negedge clk);
      peek(2'd1, v);
    end
    check("R8 irq low without enable", irq, 0);
    wr(2'd0, 16'h0002);
    check("R8 irq with enable", irq, 1);
    wr(2'd0, 16'h0000);
    check("R8 irq drops with enable", irq, 0);
    clear_flag();

    // R10 standby clear
    wr(2'd3, 16'hFFFF);
    wr(2'd2, 16'h0055);
    wr(2'd0, 16'h0001);
    standby_clr = 1'b1;
    @(negedge clk);
    standby_clr = 1'b0;
    peek(2'd2, v); check("R10 count zeroed", v, 0);
    repeat (7) @(negedge clk);
    peek(2'd2, v); check("R10 no pulse before 8", v, 0);
    @(negedge clk);
    peek(2'd2, v); check("R10 first pulse at 8", v, 1);

    // R11 match at full scale
    wr(2'd0, 16'h0000);
    wr(2'd2, 16'hFFFE);
    clear_flag();
    peek(2'd3, v); check("R11 const readback", v, 16'hFFFF);
    wr(2'd0, 16'h0001);
    v = 0;
    while (v != 16'hFFFF) begin
      @(negedge clk);
      peek(2'd2, v);
    end
    repeat (8) @(negedge clk);
    peek(2'd2, v); check("R11 wrap to zero", v, 0);
    peek(2'd1, v); check("R11 flag set", v, 1);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule